// File: doc/BRIEF.md
# Receive Queue Control and Line Status for a 16550-Style UART

This block sits behind the register decoder of a 16550-style serial port and owns three things: the receive queue, the FIFO control register and the line status register. Bytes written to the data register are looped straight into the receive queue, and data-register reads pop them back out. The queue's usable depth is one entry in character mode and the full `DEPTH` entries in FIFO mode. A byte that arrives at a full queue is dropped and latches a sticky overrun flag. The transmitter is treated as permanently idle, so line status always shows it ready.

The mode is held by a two-state machine, MODE_SINGLE and MODE_FIFO. It moves MODE_SINGLE to MODE_FIFO on an FCR write with the enable bit set, and MODE_FIFO to MODE_SINGLE on an FCR write with the enable bit clear. Any other FCR write keeps the current state. Every transition empties the queue. Reads have a one-cycle latency: `rd_data` is registered on the edge that samples `rd_en` and holds its value until the next read. Register offsets are 0 for data, 2 for FCR (write only) and 5 for LSR.

Top module: `uart_rxq_ctl`

## Requirements
- R1: After reset the queue is empty, the mode is single-entry (`fifo_mode`=0), `fcr_out`=0x00, `overrun`=0, `data_ready`=0 and `rd_data`=0x00.
- R2: An FCR write (offset 2) whose bit 0 differs from the current mode empties the queue. The usable depth becomes `DEPTH` (default 16) if bit 0 is 1, and 1 if bit 0 is 0.
- R3: An FCR write with bit 0 clear stores 0x00 and ignores every other bit. In particular, bit 1 does not flush the queue when the mode is already single-entry.
- R4: An FCR write with bit 0 set stores only bits 0, 3, 6 and 7 (the value ANDed with 0xC9). If bit 1 is also set, the queue is emptied.
- R5: A data write (offset 0) to a full queue drops the byte and sets `overrun`, which is LSR bit 1. The flag stays set through data reads until LSR is read.
- R6: An LSR read (offset 5) returns bits 5 and 6 set, bit 0 equal to "queue not empty", bit 1 equal to the overrun flag and the other bits 0. The flag clears after the read unless a new overrun happens in the same cycle; in that case the read returns the old value and the flag ends set.
- R7: A write to LSR (offset 5) changes neither the queue nor the overrun flag nor the FCR.
- R8: Data reads (offset 0) return queued bytes in arrival order. A data read from an empty queue returns 0x00 and leaves the queue unchanged.
- R9: A data write and a data read in the same cycle on a full queue both take effect: the read returns the oldest byte, the new byte is stored, and no overrun is raised.
- R10: A read of any offset other than 0 and 5 returns 0x00, and `rd_data` holds its last value in cycles without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register offset |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read register offset |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| fcr_out | output | 8 | Stored FIFO control value |
| fifo_mode | output | 1 | 1 when full-depth FIFO mode is active |
| data_ready | output | 1 | Queue holds at least one byte |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Two pairs of functions can meet in one cycle because the read and write strobes are independent. The first pair is an overrun caused by a data write and the clearing LSR read. The bench fills the single-entry queue and then drives a data write together with an LSR read. It expects that read to show no overrun and the flag to be set afterwards (R6). The second pair is a push and a pop on a full queue. The bench drives both on a full queue and expects the old head on `rd_data`, the new byte at the head afterwards and the flag still clear (R9).

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_FCR  = 3'd2;
    localparam logic [2:0] OFS_LSR  = 3'd5;

    localparam int FCR_EN_BIT    = 0;
    localparam int FCR_RXRST_BIT = 1;
    localparam logic [7:0] FCR_KEEP_MASK = 8'hC9;

    localparam int LSR_DR_BIT   = 0;
    localparam int LSR_OE_BIT   = 1;
    localparam int LSR_THRE_BIT = 5;
    localparam int LSR_TEMT_BIT = 6;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_FIFO   = 1'b1
    } rxq_mode_e;

endpackage

// File: rtl/rxq_fcr_ctl.sv
module rxq_fcr_ctl
    import uart_rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fcr_wr,
    input  logic [7:0] fcr_val,
    output logic [7:0] fcr_q,
    output rxq_mode_e  mode_q,
    output logic       flush
);

    rxq_mode_e  mode_d;
    logic [7:0] fcr_d;
    logic       en_new;

    assign en_new = fcr_val[FCR_EN_BIT];

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_SINGLE: if (fcr_wr && en_new)  mode_d = MODE_FIFO;
            MODE_FIFO:   if (fcr_wr && !en_new) mode_d = MODE_SINGLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_SINGLE;
        else        mode_q <= mode_d;
    end

    always_comb begin
        fcr_d = fcr_q;
        flush = 1'b0;
        if (fcr_wr) begin
            fcr_d = en_new ? (fcr_val & FCR_KEEP_MASK) : 8'h00;
            flush = (mode_d != mode_q) || (en_new && fcr_val[FCR_RXRST_BIT]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fcr_q <= 8'h00;
        else        fcr_q <= fcr_d;
    end

    assert_fcr_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && !fcr_val[FCR_EN_BIT]) |=> (fcr_q == 8'h00 && mode_q == MODE_SINGLE));

    assert_fcr_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr |=> ((fcr_q & ~FCR_KEEP_MASK) == 8'h00));

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             deep,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             nonempty,
    output logic             drop
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             full, pop_ok, push_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign nonempty = (count != '0);
    assign full     = deep ? (count == CW'(DEPTH)) : nonempty;
    assign pop_ok   = pop && nonempty && !flush;
    assign push_ok  = push && !flush && (!full || pop_ok);
    assign drop     = push && !flush && full && !pop_ok;
    assign head     = mem[rptr];

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop_ok)  rptr <= bump(rptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push_ok && wptr == AW'(i)) mem[i] <= push_data;
            end
        end
    endgenerate

    assert_depth_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (deep ? CW'(DEPTH) : CW'(1)));

    assert_flush_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    assert_drop_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> $stable(count));

    assert_empty_pop_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !nonempty && !push) |=> (count == '0 && $stable(rptr)));

endmodule

// File: rtl/rxq_lsr.sv
module rxq_lsr
    import uart_rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovr_event,
    input  logic       lsr_rd,
    input  logic       ready,
    output logic       ovr_q,
    output logic [7:0] lsr_byte
);

    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_event || (ovr_q && !lsr_rd);
    end

    always_comb begin
        lsr_byte               = 8'h00;
        lsr_byte[LSR_DR_BIT]   = ready;
        lsr_byte[LSR_OE_BIT]   = ovr_q;
        lsr_byte[LSR_THRE_BIT] = 1'b1;
        lsr_byte[LSR_TEMT_BIT] = 1'b1;
    end

    assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !lsr_rd) |=> ovr_q);

    assert_overrun_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_event |=> ovr_q);

    assert_overrun_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !ovr_event) |=> !ovr_q);

endmodule

// File: rtl/uart_rxq_ctl.sv
module uart_rxq_ctl
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic [7:0] fcr_out,
    output logic       fifo_mode,
    output logic       data_ready,
    output logic       overrun
);

    logic       wr_dat, wr_fcr, rd_dat, rd_lsr;
    logic       flush, drop, nonempty;
    logic [7:0] head, lsr_byte, rd_next;
    rxq_mode_e  mode;

    assign wr_dat = wr_en && (wr_addr == OFS_DATA);
    assign wr_fcr = wr_en && (wr_addr == OFS_FCR);
    assign rd_dat = rd_en && (rd_addr == OFS_DATA);
    assign rd_lsr = rd_en && (rd_addr == OFS_LSR);

    rxq_fcr_ctl u_fcr (
        .clk     (clk),
        .rst_n   (rst_n),
        .fcr_wr  (wr_fcr),
        .fcr_val (wr_data),
        .fcr_q   (fcr_out),
        .mode_q  (mode),
        .flush   (flush)
    );

    rxq_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .deep      (mode == MODE_FIFO),
        .flush     (flush),
        .push      (wr_dat),
        .push_data (wr_data),
        .pop       (rd_dat),
        .head      (head),
        .nonempty  (nonempty),
        .drop      (drop)
    );

    rxq_lsr u_lsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovr_event (drop),
        .lsr_rd    (rd_lsr),
        .ready     (nonempty),
        .ovr_q     (overrun),
        .lsr_byte  (lsr_byte)
    );

    always_comb begin
        rd_next = 8'h00;
        if (rd_dat)      rd_next = nonempty ? head : 8'h00;
        else if (rd_lsr) rd_next = lsr_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= 8'h00;
        else if (rd_en) rd_data <= rd_next;
    end

    assign fifo_mode  = (mode == MODE_FIFO);
    assign data_ready = nonempty;

    assert_lsr_tx_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lsr |=> (rd_data[6:5] == 2'b11 && rd_data[7] == 1'b0));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_other_ofs_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_dat && !rd_lsr) |=> (rd_data == 8'h00));

    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dat && !data_ready) |=> (rd_data == 8'h00));

endmodule

// File: tb/tb_uart_rxq_ctl.sv
module tb_uart_rxq_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data, fcr_out;
    logic       fifo_mode, data_ready, overrun;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] v;

    always #5 clk = ~clk;

    uart_rxq_ctl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .fcr_out(fcr_out), .fifo_mode(fifo_mode),
        .data_ready(data_ready), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic wr_rd(input logic [2:0] wa, input logic [7:0] d,
                         input logic [2:0] ra, output logic [7:0] q);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = wa; wr_data = d;
        rd_en = 1'b1; rd_addr = ra;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        q = rd_data;
    endtask

    task automatic t_reset();
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        chk(fcr_out == 8'h00, "R1 fcr", fcr_out, 0);
        chk(!fifo_mode && !data_ready && !overrun, "R1 flags",
            {fifo_mode, data_ready, overrun}, 0);
    endtask

    task automatic t_single();
        wr(3'd0, 8'h11);
        chk(data_ready, "R8 ready after push", data_ready, 1);
        wr(3'd0, 8'h22);
        chk(overrun, "R5 overrun on full single", overrun, 1);
        rd(3'd0, v);
        chk(v == 8'h11, "R8 first byte kept", v, 8'h11);
        chk(overrun, "R5 sticky through data read", overrun, 1);
        rd(3'd0, v);
        chk(v == 8'h00, "R8 empty read zero", v, 0);
        rd(3'd5, v);
        chk(v == 8'h62, "R6 lsr shows overrun", v, 8'h62);
        rd(3'd5, v);
        chk(v == 8'h60, "R6 overrun cleared after read", v, 8'h60);
        wr(3'd0, 8'h33);
        rd(3'd0, v);
        chk(v == 8'h33, "R8 empty read left queue intact", v, 8'h33);
    endtask

    task automatic t_fifo();
        wr(3'd0, 8'h44);
        wr(3'd2, 8'h01);
        chk(fifo_mode && !data_ready, "R2 enable flushes", {fifo_mode, data_ready}, 2);
        chk(fcr_out == 8'h01, "R4 fcr enable only", fcr_out, 1);
        for (int i = 0; i < 16; i++) wr(3'd0, 8'(i * 7 + 3));
        chk(!overrun, "R2 sixteen fit", overrun, 0);
        wr(3'd0, 8'hEE);
        chk(overrun, "R5 seventeenth overruns", overrun, 1);
        rd(3'd5, v);
        chk(v == 8'h63, "R6 lsr ready and overrun", v, 8'h63);
        for (int i = 0; i < 16; i++) begin
            rd(3'd0, v);
            chk(v == 8'(i * 7 + 3), "R8 order", v, i * 7 + 3);
        end
        rd(3'd5, v);
        chk(v == 8'h60, "R6 lsr empty", v, 8'h60);
    endtask

    task automatic t_fcr_bits();
        wr(3'd0, 8'h55);
        wr(3'd2, 8'hFF);
        chk(fcr_out == 8'hC9, "R4 mask", fcr_out, 8'hC9);
        chk(!data_ready, "R4 receive reset flush", data_ready, 0);
        wr(3'd0, 8'h56);
        wr(3'd2, 8'h41);
        chk(fcr_out == 8'h41 && data_ready, "R4 no reset keeps data",
            {fcr_out, 7'b0, data_ready}, 16'h4101);
        wr(3'd2, 8'hFE);
        chk(fcr_out == 8'h00 && !fifo_mode, "R3 disable clears fcr",
            {fcr_out, 7'b0, fifo_mode}, 0);
        chk(!data_ready, "R2 disable flushes", data_ready, 0);
        wr(3'd0, 8'h5A);
        wr(3'd2, 8'h02);
        chk(data_ready && fcr_out == 8'h00, "R3 reset bit ignored when disabled",
            {fcr_out, 7'b0, data_ready}, 1);
        rd(3'd0, v);
        chk(v == 8'h5A, "R3 byte survives", v, 8'h5A);
    endtask

    task automatic t_lsr_write();
        wr(3'd0, 8'h10);
        wr(3'd0, 8'h20);
        wr(3'd5, 8'h00);
        chk(overrun && data_ready && fcr_out == 8'h00, "R7 lsr write ignored",
            {overrun, data_ready}, 3);
        rd(3'd5, v);
        chk(v == 8'h63, "R7 lsr after write", v, 8'h63);
        rd(3'd0, v);
        chk(v == 8'h10, "R7 queue intact", v, 8'h10);
    endtask

    task automatic t_other();
        rd(3'd3, v);
        chk(v == 8'h00, "R10 other offset zero", v, 0);
        wr(3'd0, 8'h77);
        rd(3'd0, v);
        repeat (3) @(negedge clk);
        chk(rd_data == 8'h77, "R10 rd_data holds", rd_data, 8'h77);
    endtask

    task automatic t_collide();
        wr(3'd0, 8'hAA);
        wr_rd(3'd0, 8'hBB, 3'd0, v);
        chk(v == 8'hAA, "R9 pop returns old head", v, 8'hAA);
        chk(!overrun && data_ready, "R9 no overrun", {overrun, data_ready}, 1);
        rd(3'd0, v);
        chk(v == 8'hBB, "R9 new byte stored", v, 8'hBB);
        wr(3'd0, 8'hCC);
        wr_rd(3'd0, 8'hDD, 3'd5, v);
        chk(v == 8'h61, "R6 same-cycle read shows old flag", v, 8'h61);
        chk(overrun, "R6 new overrun survives read", overrun, 1);
        rd(3'd5, v);
        chk(v == 8'h63, "R6 flag visible next read", v, 8'h63);
        rd(3'd5, v);
        chk(v == 8'h61, "R6 flag cleared", v, 8'h61);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_fifo();
        t_fcr_bits();
        t_lsr_write();
        t_other();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule